// File: doc/BRIEF.md
# Auxiliary LED Timed Driver

This block drives the control side of an auxiliary indicator LED current source. A single register byte carries a four-bit current code and a four-bit on-time code. Writing a valid non-zero current code lights the LED at the decoded level and starts an on-time timer. When the timer runs out, the LED goes dark. One on-time code selects continuous light, with no timeout.

The LED may only be lit while the device reports Idle. Leaving Idle switches the output off in the same cycle and cancels the on-period. A later return to Idle leaves the LED dark until a new current code is written. The timer steps come from a prescaler on the system clock; one step stands for 100 ms. The block outputs the current code and its decoded milliamp value, and the analog source uses them.

Top module: `aux_led_drv`

## Requirements
- R1: After reset, `led_en_o` is 0, `led_code_o` is 0 and `led_ma_o` is 0.
- R2: While lit, `led_code_o` equals the stored current code. `led_ma_o` decodes codes 1 to 11 as 6, 10, 15, 20, 25, 33, 40, 53, 67, 80 and 100 mA.
- R3: A write (`wr_en_i` high at a clock edge) stores the current code from `wr_data_i[7:4]` and the on-time code from `wr_data_i[3:0]`. If the current code is 1 to 11 and `idle_i` is high, `led_en_o` is 1 from the cycle after that edge.
- R4: A write with current code 0 turns the LED off from the next cycle.
- R5: A write with current code 12 to 15 leaves the LED off and starts no timer. If the LED was lit, that write turns it off.
- R6: For an on-time code T from 0 to 14, the LED stays lit for exactly (T+1)*CLK_PER_STEP cycles after the write edge, and then turns off.
- R7: On-time code 15 keeps the LED lit with no timeout.
- R8: Rewriting a valid current code while the LED is lit restarts the on-time from the beginning.
- R9: While `idle_i` is low, `led_en_o`, `led_code_o` and `led_ma_o` are 0 in that same cycle. Returning to Idle does not re-light the LED.
- R10: A write of a valid code while `idle_i` is low does not light the LED, either then or after Idle returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register byte write strobe |
| wr_data_i | input | 8 | Register byte: current code [7:4], on-time code [3:0] |
| idle_i | input | 1 | High while the device is in Idle mode |
| led_en_o | output | 1 | Current source enable |
| led_code_o | output | 4 | Current code applied to the source, 0 when dark |
| led_ma_o | output | 7 | Decoded current in mA, 0 when dark |

## Verification
The assertions assume that `wr_en_i` and `idle_i` are synchronous to `clk_i` and free of X after reset. They also assume that `wr_en_i` is low while reset is held, because the write-related properties look one cycle back. The bench drives every input on the falling edge, keeps the strobe low during reset, and pulses it for exactly one cycle per write. As a result, each write is seen at a single rising edge, and each timing window can be counted from that edge.

// File: rtl/aux_led_pkg.sv
package aux_led_pkg;
  localparam int CUR_W  = 4;
  localparam int TIM_W  = 4;
  localparam int MA_W   = 7;
  localparam int CUR_MAX = 11;
  localparam logic [TIM_W-1:0] TIM_CONT = '1;

  function automatic logic [MA_W-1:0] ma_of(input logic [CUR_W-1:0] code);
    case (code)
      4'd1:    ma_of = 7'd6;
      4'd2:    ma_of = 7'd10;
      4'd3:    ma_of = 7'd15;
      4'd4:    ma_of = 7'd20;
      4'd5:    ma_of = 7'd25;
      4'd6:    ma_of = 7'd33;
      4'd7:    ma_of = 7'd40;
      4'd8:    ma_of = 7'd53;
      4'd9:    ma_of = 7'd67;
      4'd10:   ma_of = 7'd80;
      4'd11:   ma_of = 7'd100;
      default: ma_of = '0;
    endcase
  endfunction

  function automatic logic code_ok(input logic [CUR_W-1:0] code);
    code_ok = (code != '0) && (int'(code) <= CUR_MAX);
  endfunction
endpackage

// File: rtl/aux_led_tick.sv
module aux_led_tick #(
  parameter int CLK_PER_STEP = 1000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic en_i,
  output logic tick_o
);
  localparam int PRE_W = (CLK_PER_STEP > 2) ? $clog2(CLK_PER_STEP) : 1;
  localparam logic [PRE_W-1:0] PRE_MAX = PRE_W'(CLK_PER_STEP - 1);

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (en_i)    pre_q <= (pre_q == PRE_MAX) ? '0 : pre_q + 1'b1;
  end

  assign tick_o = en_i && !clear_i && (pre_q == PRE_MAX);

  // R6
  pre_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= PRE_MAX);
endmodule

// File: rtl/aux_led_timer.sv
module aux_led_timer
  import aux_led_pkg::*;
#(
  parameter int CLK_PER_STEP = 1000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [TIM_W-1:0] ton_i,
  output logic             expire_o
);
  logic             tick;
  logic             count_en;
  logic [TIM_W-1:0] step_q;

  assign count_en = run_i && (ton_i != TIM_CONT);

  aux_led_tick #(.CLK_PER_STEP(CLK_PER_STEP)) u_tick (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (start_i),
    .en_i    (count_en),
    .tick_o  (tick)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      step_q <= '0;
    else if (start_i) step_q <= '0;
    else if (tick)    step_q <= step_q + 1'b1;
  end

  assign expire_o = tick && (step_q == ton_i);

  // R6
  step_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_en |-> step_q <= ton_i);
  // R7
  cont_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ton_i == TIM_CONT) |-> !expire_o);
endmodule

// File: rtl/aux_led_drv.sv
module aux_led_drv
  import aux_led_pkg::*;
#(
  parameter int CLK_PER_STEP = 1000
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   wr_en_i,
  input  logic [CUR_W+TIM_W-1:0] wr_data_i,
  input  logic                   idle_i,
  output logic                   led_en_o,
  output logic [CUR_W-1:0]       led_code_o,
  output logic [MA_W-1:0]        led_ma_o
);
  logic [CUR_W-1:0] cur_q;
  logic [TIM_W-1:0] ton_q;
  logic             active_q;
  logic             start;
  logic             expire;
  logic [CUR_W-1:0] wr_cur;

  assign wr_cur = wr_data_i[CUR_W+TIM_W-1:TIM_W];
  assign start  = wr_en_i && idle_i && code_ok(wr_cur);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cur_q <= '0;
      ton_q <= '0;
    end else if (wr_en_i) begin
      cur_q <= wr_cur;
      ton_q <= wr_data_i[TIM_W-1:0];
    end
  end

  // leaving Idle cancels; only a fresh valid write lights
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      active_q <= 1'b0;
    else if (!idle_i) active_q <= 1'b0;
    else if (wr_en_i) active_q <= start;
    else if (expire)  active_q <= 1'b0;
  end

  aux_led_timer #(.CLK_PER_STEP(CLK_PER_STEP)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .run_i    (active_q && idle_i),
    .ton_i    (ton_q),
    .expire_o (expire)
  );

  assign led_en_o   = active_q && idle_i;
  assign led_code_o = led_en_o ? cur_q : '0;
  assign led_ma_o   = ma_of(led_code_o);

  // R2
  lit_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    led_en_o |-> (led_ma_o != '0) && code_ok(led_code_o));
  // R9
  no_relight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (led_en_o && !$past(led_en_o)) |-> $past(wr_en_i) && $past(idle_i));
  // R4
  zero_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) && ($past(wr_data_i[7:4]) == 4'd0) |-> !led_en_o);
  // R5
  bad_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) && ($past(wr_data_i[7:4]) > 4'd11) |-> !led_en_o);
  // R10
  busy_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i) && !$past(idle_i) |-> !active_q);
endmodule

// File: tb/aux_led_drv_tb.sv
module aux_led_drv_tb;
  localparam int STEP = 10;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wr_en_i = 1'b0;
  logic [7:0] wr_data_i = '0;
  logic       idle_i = 1'b1;
  logic       led_en_o;
  logic [3:0] led_code_o;
  logic [6:0] led_ma_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk_i = ~clk_i;

  aux_led_drv #(.CLK_PER_STEP(STEP)) u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .idle_i(idle_i), .led_en_o(led_en_o), .led_code_o(led_code_o), .led_ma_o(led_ma_o)
  );

  // {code, expected mA}
  localparam logic [10:0] VEC [16] = '{
    {4'd0, 7'd0},   {4'd1, 7'd6},   {4'd2, 7'd10},  {4'd3, 7'd15},
    {4'd4, 7'd20},  {4'd5, 7'd25},  {4'd6, 7'd33},  {4'd7, 7'd40},
    {4'd8, 7'd53},  {4'd9, 7'd67},  {4'd10, 7'd80}, {4'd11, 7'd100},
    {4'd12, 7'd0},  {4'd13, 7'd0},  {4'd14, 7'd0},  {4'd15, 7'd0}
  };

  task automatic chk(input int act, input int exp, input string req);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    wr_data_i = d;
    wr_en_i   = 1'b1;
    @(negedge clk_i);
    wr_en_i   = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk_i);
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    chk(led_en_o, 0, "R1 en");
    chk(led_code_o, 0, "R1 code");
    chk(led_ma_o, 0, "R1 ma");
    rst_ni = 1'b1;
    wait_cyc(2);

    // R2 R3 R5: table walk, continuous on-time
    for (int i = 0; i < 16; i++) begin
      wr({VEC[i][10:7], 4'hF});
      chk(led_en_o, (VEC[i][6:0] != 0) ? 1 : 0, "R3 en");
      chk(led_code_o, (VEC[i][6:0] != 0) ? int'(VEC[i][10:7]) : 0, "R2 code");
      chk(led_ma_o, VEC[i][6:0], "R2 ma");
    end

    // R6: T=3 -> 40 cycles
    wr(8'h13);
    wait_cyc(4 * STEP - 1);
    chk(led_en_o, 1, "R6 last lit");
    wait_cyc(1);
    chk(led_en_o, 0, "R6 expired");
    wait_cyc(30);
    chk(led_en_o, 0, "R6 stays off");

    // R6: T=0 -> 10 cycles
    wr(8'h40);
    wait_cyc(STEP - 1);
    chk(led_en_o, 1, "R6 t0 lit");
    wait_cyc(1);
    chk(led_en_o, 0, "R6 t0 off");

    // R8: restart
    wr(8'h21);
    wait_cyc(15);
    wr(8'h21);
    wait_cyc(2 * STEP - 1);
    chk(led_en_o, 1, "R8 restarted");
    wait_cyc(1);
    chk(led_en_o, 0, "R8 off");

    // R7: continuous
    wr(8'hBF);
    wait_cyc(20 * STEP);
    chk(led_en_o, 1, "R7 cont");
    chk(led_ma_o, 100, "R7 ma");

    // R4: zero off
    wr(8'h0F);
    chk(led_en_o, 0, "R4 off");

    // R5: bad code turns off lit LED
    wr(8'h5F);
    wr(8'hD5);
    chk(led_en_o, 0, "R5 off");
    wait_cyc(3 * STEP);
    chk(led_en_o, 0, "R5 no timer");

    // R9: leave Idle
    wr(8'h6F);
    #2 idle_i = 1'b0;
    #1;
    chk(led_en_o, 0, "R9 en");
    chk(led_ma_o, 0, "R9 ma");
    wait_cyc(3);
    idle_i = 1'b1;
    wait_cyc(3);
    chk(led_en_o, 0, "R9 no relight");

    // R9: cancel a timed period
    wr(8'h72);
    wait_cyc(5);
    idle_i = 1'b0;
    wait_cyc(2);
    idle_i = 1'b1;
    wait_cyc(2);
    chk(led_en_o, 0, "R9 cancelled");

    // R10: write while not Idle
    idle_i = 1'b0;
    wr(8'h3F);
    wait_cyc(2);
    idle_i = 1'b1;
    wait_cyc(3);
    chk(led_en_o, 0, "R10 ignored");
    chk(led_code_o, 0, "R10 code");

    // R1: reset mid-operation
    wr(8'h9F);
    rst_ni = 1'b0;
    #1;
    chk(led_en_o, 0, "R1 async");
    wait_cyc(2);
    rst_ni = 1'b1;
    wait_cyc(2);
    chk(led_en_o, 0, "R1 after");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule